// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host read and write a small byte-wide register file over four pins: a chip-enable, a shift clock, a serial data input and a serial data output with an output-enable. The host raises chip-enable and then shifts in a 4-bit mode nibble. A 4-bit register address follows, and then one or more 8-bit data bytes. Every field goes most significant bit first. In a write frame the bytes are shifted in. In a read frame the addressed bytes are shifted out. After each byte the address steps forward, wrapping at the end of the file, so one frame can cover a run of registers.

The whole block runs on one system clock. The serial pins are registered, and the edges of the shift clock are found by comparing samples, so the shift clock must be several times slower than the system clock. Data-in is taken on rising shift-clock edges. Data-out changes on falling edges and is driven only during the data phase of a valid read. A write-lock input lets surrounding logic refuse a byte at the moment it would be stored. A window limit ends a chip-enable window that stays open too long: once the limit is reached the slave stays silent until chip-enable falls.

Top module: `serreg_slave`

## Requirements
- R1: While chip-enable is low, the output-enable is low and shift-clock and data-in activity has no effect on the register file.
- R2: A frame is 4 mode bits, then 4 address bits, then 8-bit data bytes, each field shifted most significant bit first. A written byte reads back unchanged.
- R3: Mode nibble encoding: bit 3 = 1 selects read and bit 3 = 0 selects write. Bit 2 is reserved and must be 0. Bits 1..0 select the bank, where 00 is the register bank. A frame with any nonzero value in bits 2..0 is ignored to its end: it writes nothing and never enables data-out.
- R4: Data-in is sampled on rising shift-clock edges. Data-out changes only on falling edges. The first data bit of a read appears on the falling edge after the last address bit, so the output-enable is still low during the high phase of that address bit.
- R5: The output-enable is high only in the data phase of a valid read frame. It stays low for the whole of a write frame and for the mode and address phases of a read frame.
- R6: After each complete data byte the address increments modulo 16, for both reads and writes. Address 15 is followed by address 0.
- R7: A byte is stored only when all 8 of its bits have been received. If chip-enable falls mid-byte, that byte is not stored.
- R8: If the write-lock input is high on the clock cycle in which a byte completes, that byte is dropped. Later bytes in the same burst are stored normally if the lock is low for them.
- R9: Once chip-enable has been high for WINDOW_CYC system clocks, the slave ignores the rest of the frame: it stores nothing and drops the output-enable. Normal operation resumes with the next chip-enable window.
- R10: After reset, the output-enable and the data-out are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Chip-enable from the host, active high |
| sck_i | input | 1 | Serial shift clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| wr_lock_i | input | 1 | When high, a byte completing in this cycle is not stored |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Drive enable for sdo_o; the pad is high impedance when low |

## Verification
The bench writes to the last address and bursts across it, which catches an address counter that saturates or spills into a fifth bit instead of wrapping to 0. It sends frames cut off after five data bits, with the lock raised, in the memory bank and with the reserved bit set, and in each case reads the target register back. A design that stored partial bytes, ignored the lock or trusted any mode nibble would overwrite that register. It watches the output-enable through write frames, through read headers and while chip-enable is low, which exposes a data-out that drives too early or leaks onto the shared line. A long burst runs past the window limit, so a slave that never times out would both store the late bytes and keep driving.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  typedef enum logic [1:0] {
    PH_MODE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;
endpackage

// File: rtl/serreg_edge.sv
// Registers the serial pins on the system clock and marks shift-clock edges.
module serreg_edge (
  input  logic clk,
  input  logic rst,
  input  logic ce_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic ce_s,
  output logic sdi_s,
  output logic sck_rise,
  output logic sck_fall
);
  logic sck_s, sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_s  <= 1'b0;
      sck_s <= 1'b0;
      sck_d <= 1'b0;
      sdi_s <= 1'b0;
    end else begin
      ce_s  <= ce_i;
      sck_s <= sck_i;
      sck_d <= sck_s;
      sdi_s <= sdi_i;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
endmodule

// File: rtl/serreg_regfile.sv
// Byte register file: one write port, one asynchronous read port.
module serreg_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic              lock_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i && !lock_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

  // R8: a locked byte leaves the target entry untouched
  p_lock_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (we_i && lock_i) |=> mem[$past(waddr_i)] == $past(mem[waddr_i]));

  // R7: a completed, unlocked byte lands in the addressed entry
  p_byte_lands_r7: assert property (@(posedge clk) disable iff (rst)
    (we_i && !lock_i) |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/serreg_frame_ctl.sv
// Frame parser: mode, address and data phases, burst addressing, read shifter.
module serreg_frame_ctl
  import serreg_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int MODE_W     = 4,
  parameter int WINDOW_CYC = 50_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_s,
  input  logic              sdi_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int WIN_W = $clog2(WINDOW_CYC + 1);
  localparam logic [CNT_W-1:0] MODE_LAST = CNT_W'(MODE_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [WIN_W-1:0] WIN_LAST  = WIN_W'(WINDOW_CYC - 1);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh_in, sh_out, nxt;
  logic [ADDR_W-1:0] addr;
  logic [WIN_W-1:0]  win_cnt;
  logic              is_rd, expired, tmo, act, byte_end;

  always_comb begin
    nxt      = {sh_in[DATA_W-2:0], sdi_s};
    tmo      = (win_cnt == WIN_LAST);
    act      = ce_s && !expired && !tmo && (phase != PH_SKIP);
    byte_end = sck_rise && act && (phase == PH_DATA) && (cnt == DATA_LAST);
    raddr_o  = (phase == PH_ADDR) ? nxt[ADDR_W-1:0] : addr + ADDR_W'(1);
    we_o     = byte_end && !is_rd;
    waddr_o  = addr;
    wdata_o  = nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || !ce_s) begin
      phase    <= PH_MODE;
      cnt      <= '0;
      win_cnt  <= '0;
      expired  <= 1'b0;
      is_rd    <= 1'b0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
      if (rst) begin
        sh_in  <= '0;
        sh_out <= '0;
        addr   <= '0;
      end
    end else begin
      if (!expired && !tmo) win_cnt <= win_cnt + WIN_W'(1);
      if (tmo) begin
        expired  <= 1'b1;
        phase    <= PH_SKIP;
        sdo_oe_o <= 1'b0;
      end
      if (sck_rise && act) begin
        sh_in <= nxt;
        cnt   <= cnt + CNT_W'(1);
        case (phase)
          PH_MODE: if (cnt == MODE_LAST) begin
            cnt <= '0;
            if (nxt[MODE_W-2:0] == '0) begin
              is_rd <= nxt[MODE_W-1];
              phase <= PH_ADDR;
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_ADDR: if (cnt == ADDR_LAST) begin
            cnt    <= '0;
            addr   <= nxt[ADDR_W-1:0];
            phase  <= PH_DATA;
            sh_out <= rdata_i;
          end
          PH_DATA: if (cnt == DATA_LAST) begin
            cnt    <= '0;
            addr   <= addr + ADDR_W'(1);
            sh_out <= rdata_i;
          end
          default: ;
        endcase
      end
      if (sck_fall && act && (phase == PH_DATA) && is_rd) begin
        sdo_o    <= sh_out[DATA_W-1];
        sh_out   <= {sh_out[DATA_W-2:0], 1'b0};
        sdo_oe_o <= 1'b1;
      end
    end
  end

  // R1: chip-enable low releases the data-out line
  p_idle_release_r1: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> !sdo_oe_o);

  // R5: output drive only in the data phase of a read frame
  p_oe_read_data_r5: assert property (@(posedge clk) disable iff (rst)
    sdo_oe_o |-> (is_rd && phase == PH_DATA));

  // R4: data-out moves only on a falling shift-clock edge
  p_dout_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (ce_s && !sck_fall) |=> $stable(sdo_o));

  // R3: a nibble outside the register bank parks the frame
  p_bad_mode_skip_r3: assert property (@(posedge clk) disable iff (rst)
    (sck_rise && act && phase == PH_MODE && cnt == MODE_LAST &&
     nxt[MODE_W-2:0] != '0) |=> phase == PH_SKIP);

  // R6: the burst address steps by one, wrapping at the top
  p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
    byte_end |=> addr == $past(addr) + ADDR_W'(1));

  // R9: after the window limit nothing is driven or stored
  p_window_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    expired |-> (!sdo_oe_o && !we_o));
endmodule

// File: rtl/serreg_slave.sv
// Top: serial register access slave.
module serreg_slave #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int MODE_W     = 4,
  parameter int WINDOW_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_i,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic wr_lock_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic              ce_s, sdi_s, sck_rise, sck_fall, we;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [DATA_W-1:0] rdata, wdata;

  serreg_edge u_edge (
    .clk(clk), .rst(rst), .ce_i(ce_i), .sck_i(sck_i), .sdi_i(sdi_i),
    .ce_s(ce_s), .sdi_s(sdi_s), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  serreg_frame_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .WINDOW_CYC(WINDOW_CYC)
  ) u_ctl (
    .clk(clk), .rst(rst), .ce_s(ce_s), .sdi_s(sdi_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .rdata_i(rdata),
    .raddr_o(raddr), .waddr_o(waddr), .wdata_o(wdata), .we_o(we),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  serreg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst(rst), .we_i(we), .lock_i(wr_lock_i),
    .waddr_i(waddr), .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rdata)
  );
endmodule

// File: tb/serreg_slave_bench.sv
module serreg_slave_bench;
  localparam int H = 4;      // system clocks per shift-clock half period
  localparam int WIN = 400;  // shortened window limit for R9

  logic clk = 1'b0, rst = 1'b1;
  logic ce = 1'b0, sck = 1'b0, sdi = 1'b0, lock = 1'b0;
  logic sdo, sdo_oe;
  int total = 0, bad = 0;
  logic [7:0] model [16];

  always #10 clk = ~clk;

  serreg_slave #(.WINDOW_CYC(WIN)) u_serreg_slave (
    .clk(clk), .rst(rst), .ce_i(ce), .sck_i(sck), .sdi_i(sdi),
    .wr_lock_i(lock), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  // Stimulus table: {address, data}
  localparam logic [11:0] VEC [8] = '{
    {4'd3, 8'h00}, {4'd7, 8'hFF}, {4'd0, 8'hA5}, {4'd15, 8'h5A},
    {4'd8, 8'h01}, {4'd12, 8'h80}, {4'd1, 8'h3C}, {4'd14, 8'hC3}
  };

  task automatic check(input logic ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o, output logic oe);
    @(negedge clk); sck = 1'b0; sdi = b;
    repeat (H - 1) @(negedge clk);
    o = sdo; oe = sdo_oe;
    @(negedge clk); sck = 1'b1;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic ce_up();
    @(negedge clk); ce = 1'b1; sck = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic ce_down();
    @(negedge clk); ce = 1'b0; sck = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic hdr(input logic [3:0] m, input logic [3:0] a, output logic any_oe);
    logic o, oe;
    any_oe = 1'b0;
    for (int i = 3; i >= 0; i--) begin bit_io(m[i], o, oe); any_oe |= oe; end
    for (int i = 3; i >= 0; i--) begin bit_io(a[i], o, oe); any_oe |= oe; end
  endtask

  task automatic byte_io(input logic [7:0] w, output logic [7:0] r,
                         output logic all_oe, output logic any_oe);
    logic o, oe;
    all_oe = 1'b1; any_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_io(w[i], o, oe); r[i] = o; all_oe &= oe; any_oe |= oe;
    end
  endtask

  task automatic wr1(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] r; logic ao, an, ho;
    ce_up(); hdr(4'b0000, a, ho); byte_io(d, r, ao, an); ce_down();
  endtask

  task automatic rd1(input logic [3:0] a, output logic [7:0] r);
    logic ao, an, ho;
    ce_up(); hdr(4'b1000, a, ho); byte_io(8'h00, r, ao, an); ce_down();
  endtask

  initial begin
    logic [7:0] r;
    logic ao, an, ho, o, oe;

    repeat (4) @(negedge clk);
    check(sdo_oe == 1'b0, "R10 oe after reset", {7'd0, sdo_oe}, 8'h00);
    check(sdo == 1'b0, "R10 sdo after reset", {7'd0, sdo}, 8'h00);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      model[i] = 8'hA0 + 8'(i);
      wr1(4'(i), model[i]);
    end

    // R9: long write burst crosses the window limit
    ce_up(); hdr(4'b0000, 4'd0, ho);
    for (int k = 0; k < 10; k++) byte_io(8'h50 + 8'(k), r, ao, an);
    ce_down();
    for (int k = 0; k < 10; k++) begin
      if (k == 4) continue;
      if (k < 4) model[k] = 8'h50 + 8'(k);
      rd1(4'(k), r);
      check(r == model[k], "R9 burst store before/after limit", r, model[k]);
    end
    wr1(4'd4, model[4]);
    // R9: long read burst loses drive after the limit
    ce_up(); hdr(4'b1000, 4'd0, ho);
    byte_io(8'h00, r, ao, an);
    check(r == model[0] && ao, "R9 first byte before limit", r, model[0]);
    for (int k = 1; k < 8; k++) byte_io(8'h00, r, ao, an);
    check(!an, "R9 oe dropped after limit", {7'd0, an}, 8'h00);
    ce_down();

    // R2: table of single writes read back
    for (int v = 0; v < 8; v++) begin
      model[VEC[v][11:8]] = VEC[v][7:0];
      wr1(VEC[v][11:8], VEC[v][7:0]);
      rd1(VEC[v][11:8], r);
      check(r == VEC[v][7:0], "R2 write/read vector", r, VEC[v][7:0]);
    end

    // R4/R5: header of a read keeps oe low; data phase drives
    ce_up(); hdr(4'b1000, 4'd7, ho);
    check(!ho, "R4 R5 oe low through read header", {7'd0, ho}, 8'h00);
    byte_io(8'h00, r, ao, an);
    check(ao && r == model[7], "R5 read data phase driven", r, model[7]);
    ce_down();
    ce_up(); hdr(4'b0000, 4'd6, ho);
    byte_io(8'h99, r, ao, an); model[6] = 8'h99;
    check(!ho && !an, "R5 oe low in write frame", {7'd0, an | ho}, 8'h00);
    ce_down();

    // R1: activity while chip-enable is low
    begin
      logic [15:0] pat = {4'b0000, 4'd2, 8'h77};
      logic seen = 1'b0;
      for (int i = 15; i >= 0; i--) begin bit_io(pat[i], o, oe); seen |= oe; end
      check(!seen, "R1 oe low while ce low", {7'd0, seen}, 8'h00);
    end
    rd1(4'd2, r);
    check(r == model[2], "R1 no write while ce low", r, model[2]);

    // R3: unsupported banks and reserved bit
    wr1(4'd2, 8'h00);  // placeholder overwritten below
    model[2] = 8'h00;
    ce_up(); hdr(4'b0010, 4'd2, ho); byte_io(8'hE1, r, ao, an); ce_down();
    rd1(4'd2, r);
    check(r == model[2], "R3 memory-bank write ignored", r, model[2]);
    ce_up(); hdr(4'b0100, 4'd2, ho); byte_io(8'hE2, r, ao, an); ce_down();
    rd1(4'd2, r);
    check(r == model[2], "R3 reserved-bit write ignored", r, model[2]);
    ce_up(); hdr(4'b1010, 4'd2, ho); byte_io(8'h00, r, ao, an); ce_down();
    check(!an, "R3 memory-bank read not driven", {7'd0, an}, 8'h00);

    // R6: burst wraps from 15 to 0
    ce_up(); hdr(4'b0000, 4'd15, ho);
    byte_io(8'h12, r, ao, an); byte_io(8'h34, r, ao, an); byte_io(8'h56, r, ao, an);
    ce_down();
    model[15] = 8'h12; model[0] = 8'h34; model[1] = 8'h56;
    rd1(4'd0, r);
    check(r == 8'h34, "R6 write burst wraps to 0", r, 8'h34);
    ce_up(); hdr(4'b1000, 4'd15, ho);
    byte_io(8'h00, r, ao, an); check(r == 8'h12, "R6 read burst at 15", r, 8'h12);
    byte_io(8'h00, r, ao, an); check(r == 8'h34, "R6 read burst wraps 0", r, 8'h34);
    byte_io(8'h00, r, ao, an); check(r == 8'h56, "R6 read burst at 1", r, 8'h56);
    ce_down();

    // R7: truncated byte
    ce_up(); hdr(4'b0000, 4'd9, ho);
    for (int i = 0; i < 5; i++) bit_io(1'b1, o, oe);
    ce_down();
    rd1(4'd9, r);
    check(r == model[9], "R7 partial byte not stored", r, model[9]);

    // R8: write lock
    ce_up(); hdr(4'b0000, 4'd5, ho);
    @(negedge clk); lock = 1'b1;
    byte_io(8'hEE, r, ao, an);
    @(negedge clk); lock = 1'b0;
    byte_io(8'hDD, r, ao, an);
    ce_down();
    model[6] = 8'hDD;
    rd1(4'd5, r);
    check(r == model[5], "R8 locked byte dropped", r, model[5]);
    rd1(4'd6, r);
    check(r == 8'hDD, "R8 next byte stored", r, 8'hDD);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule